// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block is the trap unit of a five-stage in-order pipeline. Each cycle it looks at three sources: an undefined-opcode flag from the decode stage, an arithmetic-overflow flag from the execute stage, and an external interrupt line. When one of them must be taken, it picks the one that belongs to the oldest instruction. In the same cycle it drives the flush signals that zero the control fields of the pipeline registers holding the faulting instruction and everything younger. It also redirects fetch to the handler entry point.

On the clock edge that takes the trap, the unit loads the saved-PC register with the victim instruction's PC plus 4 and loads the cause register with a code. The handler subtracts 4 to find the instruction to restart. A two-entry read port exposes both registers. The handler address is either one fixed base or, when the vectored option is set, a base plus a per-cause offset. Older instructions already past the faulting stage complete normally.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset the saved PC and the cause register both read 0, and redirect and all three flush outputs are low while no request is present.
- R2: An overflow on a valid execute-stage instruction raises redirect, flush_fetch, flush_decode and flush_execute in the same cycle, so the faulting instruction never writes its destination.
- R3: An undefined opcode on a valid decode-stage instruction, with no execute-stage overflow, raises redirect, flush_fetch and flush_decode in the same cycle and leaves flush_execute low, so the older execute-stage instruction completes.
- R4: When an execute-stage overflow and a decode-stage undefined opcode arrive in one cycle, the overflow is taken: the saved PC becomes the execute-stage PC plus 4 and the cause code is 1.
- R5: On the edge that takes a trap, the saved PC is loaded with the victim's PC plus 4; rd_data shows it with rd_sel = 0 from the cycle after.
- R6: The cause code is 0 for undefined opcode, 1 for overflow and 2 for interrupt, read zero-extended on rd_data with rd_sel = 1 from the cycle after the trap.
- R7: An interrupt is taken only when a valid instruction is in decode and no synchronous trap is taken that cycle. It then flushes like R3 and saves that decode PC plus 4. An interrupt with no valid decode instruction does nothing.
- R8: The saved PC and cause register hold their values on every cycle that takes no trap.
- R9: With VECTORED = 0, redirect_pc equals HANDLER_BASE for every cause. With VECTORED = 1, it equals HANDLER_BASE + code * VEC_STRIDE.
- R10: An overflow flag with ex_valid low, or an undefined-opcode flag with id_valid low, causes no redirect, no flush and no register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_illegal | input | 1 | Decode stage instruction has an undefined opcode |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute stage instruction overflowed |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| irq | input | 1 | External interrupt request (level) |
| redirect | output | 1 | Fetch must jump to redirect_pc this cycle |
| redirect_pc | output | XLEN | Handler entry address |
| flush_fetch | output | 1 | Zero the fetch/decode pipeline register |
| flush_decode | output | 1 | Zero the control fields entering decode/execute |
| flush_execute | output | 1 | Zero the control fields entering execute/memory |
| rd_sel | input | 1 | Read select: 0 saved PC, 1 cause |
| rd_data | output | XLEN | Selected register value |

## Verification
Redirect, redirect_pc and the three flush lines are combinational in the request inputs. The bench checks them one time unit after driving on the falling edge, so the check falls before the rising edge that could change state. The saved PC and cause are due one edge later. The bench samples rd_data one unit after that rising edge, with the requests already removed, and toggles rd_sel between the two reads. Cases that must leave state alone are checked by reading both registers after the edge that follows the stimulus.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int CODE_W = 2;
   typedef enum logic [CODE_W-1:0] {
      TC_UNDEF = 2'd0,
      TC_OVF   = 2'd1,
      TC_IRQ   = 2'd2
   } trap_code_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            id_valid,
   input  logic            id_illegal,
   input  logic [XLEN-1:0] id_pc,
   input  logic            ex_valid,
   input  logic            ex_ovf,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            irq,
   output logic            take,
   output trap_code_e      code,
   output logic [XLEN-1:0] victim_pc,
   output logic            kill_fetch,
   output logic            kill_decode,
   output logic            kill_execute
);
   logic hit_ex, hit_id, hit_irq;

   // oldest first: execute beats decode beats interrupt
   always_comb begin
      hit_ex  = ex_valid & ex_ovf;
      hit_id  = id_valid & id_illegal & ~hit_ex;
      hit_irq = id_valid & irq & ~hit_ex & ~hit_id;
      take    = hit_ex | hit_id | hit_irq;
      if (hit_ex) begin
         code      = TC_OVF;
         victim_pc = ex_pc;
      end else if (hit_id) begin
         code      = TC_UNDEF;
         victim_pc = id_pc;
      end else begin
         code      = TC_IRQ;
         victim_pc = id_pc;
      end
      kill_fetch   = take;
      kill_decode  = take;
      kill_execute = hit_ex;
   end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
   import trap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  trap_code_e      code,
   input  logic [XLEN-1:0] victim_pc,
   input  logic            rd_sel,
   output logic [XLEN-1:0] rd_data
);
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   logic [XLEN-1:0]   epc_q;
   logic [CODE_W-1:0] cause_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q   <= '0;
         cause_q <= '0;
      end else if (take) begin
         epc_q   <= victim_pc + PC_STEP;
         cause_q <= code;
      end
   end

   assign rd_data = rd_sel ? XLEN'(cause_q) : epc_q;

   p_saved_pc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (epc_q == $past(victim_pc) + PC_STEP));

   p_cause_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cause_q == $past(code)));

   p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(epc_q) && $stable(cause_q)));
endmodule

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter bit              VECTORED     = 1'b0,
   parameter logic [XLEN-1:0] HANDLER_BASE = '0,
   parameter int              VEC_STRIDE   = 32
) (
   input  trap_code_e      code,
   output logic [XLEN-1:0] target
);
   generate
      if (VECTORED) begin : g_vec
         localparam logic [XLEN-1:0] STRIDE = XLEN'(VEC_STRIDE);
         assign target = HANDLER_BASE + XLEN'(code) * STRIDE;
      end else begin : g_flat
         logic unused_code;
         assign unused_code = ^code;
         assign target = HANDLER_BASE;
      end
   endgenerate
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
   import trap_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter bit              VECTORED     = 1'b0,
   parameter logic [XLEN-1:0] HANDLER_BASE = 32'h8000_0180,
   parameter int              VEC_STRIDE   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            id_valid,
   input  logic            id_illegal,
   input  logic [XLEN-1:0] id_pc,
   input  logic            ex_valid,
   input  logic            ex_ovf,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            irq,
   output logic            redirect,
   output logic [XLEN-1:0] redirect_pc,
   output logic            flush_fetch,
   output logic            flush_decode,
   output logic            flush_execute,
   input  logic            rd_sel,
   output logic [XLEN-1:0] rd_data
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("precise_trap_unit: XLEN must be at least 8");
      end
      if (VEC_STRIDE < 4 || (VEC_STRIDE % 4) != 0) begin : g_bad_stride
         $error("precise_trap_unit: VEC_STRIDE must be a positive multiple of 4");
      end
   endgenerate

   logic            take;
   trap_code_e      code;
   logic [XLEN-1:0] victim_pc;

   trap_arbiter #(.XLEN(XLEN)) arb_i (
      .id_valid     (id_valid),
      .id_illegal   (id_illegal),
      .id_pc        (id_pc),
      .ex_valid     (ex_valid),
      .ex_ovf       (ex_ovf),
      .ex_pc        (ex_pc),
      .irq          (irq),
      .take         (take),
      .code         (code),
      .victim_pc    (victim_pc),
      .kill_fetch   (flush_fetch),
      .kill_decode  (flush_decode),
      .kill_execute (flush_execute)
   );

   trap_regs #(.XLEN(XLEN)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .code      (code),
      .victim_pc (victim_pc),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data)
   );

   trap_vector #(
      .XLEN         (XLEN),
      .VECTORED     (VECTORED),
      .HANDLER_BASE (HANDLER_BASE),
      .VEC_STRIDE   (VEC_STRIDE)
   ) vec_i (
      .code   (code),
      .target (redirect_pc)
   );

   assign redirect = take;

   p_ovf_flush_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_ovf) |-> (redirect && flush_fetch && flush_decode && flush_execute));

   p_undef_keeps_ex_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && id_illegal && !(ex_valid && ex_ovf)) |->
         (redirect && flush_decode && !flush_execute));

   p_oldest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_ovf) |-> (code == TC_OVF && victim_pc == ex_pc));

   p_irq_yields_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code == TC_IRQ && redirect) |-> (id_valid && irq && !id_illegal && !(ex_valid && ex_ovf)));

   p_no_slot_no_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_valid && !id_valid) |-> !(redirect || flush_fetch || flush_decode || flush_execute));

   p_flush_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flush_fetch, flush_decode, flush_execute}) != 0 |-> (flush_fetch && flush_decode));
endmodule

// File: tb/precise_trap_unit_tb_top.sv
module precise_trap_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] FLAT_BASE = 32'h8000_0180;
   localparam logic [31:0] VEC_BASE  = 32'h8000_0000;
   localparam int          STRIDE    = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        id_valid = 1'b0, id_illegal = 1'b0, ex_valid = 1'b0, ex_ovf = 1'b0, irq = 1'b0;
   logic [31:0] id_pc = '0, ex_pc = '0;
   logic        rd_sel = 1'b0;
   logic        redirect, flush_fetch, flush_decode, flush_execute;
   logic [31:0] redirect_pc, rd_data;
   logic        v_redirect, v_ff, v_fd, v_fe;
   logic [31:0] v_redirect_pc, v_rd_data;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   precise_trap_unit #(.XLEN(32), .VECTORED(1'b0), .HANDLER_BASE(FLAT_BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_illegal(id_illegal), .id_pc(id_pc),
      .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .irq(irq),
      .redirect(redirect), .redirect_pc(redirect_pc), .flush_fetch(flush_fetch),
      .flush_decode(flush_decode), .flush_execute(flush_execute),
      .rd_sel(rd_sel), .rd_data(rd_data));

   precise_trap_unit #(.XLEN(32), .VECTORED(1'b1), .HANDLER_BASE(VEC_BASE), .VEC_STRIDE(STRIDE)) dut_vec_i (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_illegal(id_illegal), .id_pc(id_pc),
      .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .irq(irq),
      .redirect(v_redirect), .redirect_pc(v_redirect_pc), .flush_fetch(v_ff),
      .flush_decode(v_fd), .flush_execute(v_fe),
      .rd_sel(rd_sel), .rd_data(v_rd_data));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      id_valid = 0; id_illegal = 0; ex_valid = 0; ex_ovf = 0; irq = 0;
      id_pc = '0; ex_pc = '0;
   endtask

   // read both saved registers through the port (called after a rising edge)
   task automatic read_regs(input string req, input logic [31:0] epc_exp, input logic [31:0] cause_exp);
      rd_sel = 0; #1;
      chk({req, " saved pc"}, rd_data, epc_exp);
      rd_sel = 1; #1;
      chk({req, " cause"}, rd_data, cause_exp);
      rd_sel = 0;
   endtask

   // drive on falling edge, check combinational outputs, then the edge, then registers
   task automatic flushes(input string req, input logic [3:0] exp);
      chk(req, {29'd0, redirect, flush_fetch, flush_decode} << 1 | {31'd0, flush_execute},
          {28'd0, exp});
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1; flushes("R1 outputs idle", 4'b0000);
      read_regs("R1", 32'h0, 32'h0);
   endtask

   task automatic t_overflow();
      @(negedge clk);
      ex_valid = 1; ex_ovf = 1; ex_pc = 32'h100; id_valid = 1; id_pc = 32'h104;
      #1;
      flushes("R2 overflow flush", 4'b1111);
      chk("R9 flat target ovf", redirect_pc, FLAT_BASE);
      chk("R9 vector target ovf", v_redirect_pc, VEC_BASE + 32'd32);
      @(posedge clk); #1; idle_inputs();
      read_regs("R5 R6 overflow", 32'h104, 32'd1);
   endtask

   task automatic t_undef();
      @(negedge clk);
      id_valid = 1; id_illegal = 1; id_pc = 32'h200; ex_valid = 1; ex_pc = 32'h1fc;
      #1;
      flushes("R3 undef flush", 4'b1110);
      chk("R9 flat target undef", redirect_pc, FLAT_BASE);
      chk("R9 vector target undef", v_redirect_pc, VEC_BASE);
      @(posedge clk); #1; idle_inputs();
      read_regs("R5 R6 undef", 32'h204, 32'd0);
   endtask

   task automatic t_both();
      @(negedge clk);
      ex_valid = 1; ex_ovf = 1; ex_pc = 32'h300; id_valid = 1; id_illegal = 1; id_pc = 32'h304;
      irq = 1;
      #1;
      flushes("R4 both flush", 4'b1111);
      @(posedge clk); #1; idle_inputs();
      read_regs("R4 oldest wins", 32'h304, 32'd1);
   endtask

   task automatic t_irq();
      @(negedge clk);
      irq = 1; id_valid = 1; id_pc = 32'h400; ex_valid = 1; ex_pc = 32'h3fc;
      #1;
      flushes("R7 irq flush", 4'b1110);
      chk("R9 flat target irq", redirect_pc, FLAT_BASE);
      chk("R9 vector target irq", v_redirect_pc, VEC_BASE + 32'd64);
      @(posedge clk); #1; idle_inputs();
      read_regs("R7 R6 irq", 32'h404, 32'd2);
      chk("R9 vectored regs agree", v_rd_data, 32'h404);
   endtask

   task automatic t_irq_vs_ovf();
      @(negedge clk);
      irq = 1; id_valid = 1; id_pc = 32'h504; ex_valid = 1; ex_ovf = 1; ex_pc = 32'h500;
      #1;
      flushes("R7 irq yields flush", 4'b1111);
      @(posedge clk); #1; idle_inputs();
      read_regs("R7 irq yields", 32'h504, 32'd1);
   endtask

   task automatic t_irq_no_boundary();
      @(negedge clk);
      irq = 1; id_valid = 0; id_pc = 32'h600; ex_valid = 1; ex_pc = 32'h5fc;
      #1;
      flushes("R7 irq without decode slot", 4'b0000);
      @(posedge clk); #1; idle_inputs();
      read_regs("R7 irq ignored", 32'h504, 32'd1);
   endtask

   task automatic t_invalid_slots();
      @(negedge clk);
      ex_valid = 0; ex_ovf = 1; ex_pc = 32'h700; id_valid = 0; id_illegal = 1; id_pc = 32'h704;
      #1;
      flushes("R10 invalid slots", 4'b0000);
      @(posedge clk); #1; idle_inputs();
      read_regs("R10 no update", 32'h504, 32'd1);
   endtask

   task automatic t_hold();
      @(negedge clk);
      id_valid = 1; id_pc = 32'h800; ex_valid = 1; ex_pc = 32'h7fc;
      for (int i = 0; i < 5; i++) @(posedge clk);
      #1; idle_inputs();
      read_regs("R8 hold", 32'h504, 32'd1);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_overflow();
      t_undef();
      t_both();
      t_irq();
      t_irq_vs_ovf();
      t_irq_no_boundary();
      t_invalid_slots();
      t_hold();
      repeat (2) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule